// File: doc/BRIEF.md
# Pinned Writeback Completion Scoreboard

This block sits between writeback and the issue logic of an out-of-order core. It records, for each physical register, whether its value is ready. On each completed write it decides whether the destination now becomes ready and whether waiting consumers should be woken. Some registers are written in several disjoint parts by a run of micro-operations that share one physical register. For such a register the block counts the partial writes still outstanding. It declares readiness, and broadcasts a single wakeup, only when the last part lands.

Rename programs each entry through a load port. The load carries the number of extra pinned writes N, and the entry's outstanding count becomes N+1. A separate clear port marks a freshly renamed destination as not ready. Writeback presents a physical index and the tag of the completing instruction. One cycle later the block reports that instruction's completion, flags it if the register it wrote was pinned, and pulses the wakeup broadcast when the register became complete.

Top module: `pinwb_scoreboard`

## Requirements
- R1: After reset every entry reads ready (`ready_o` all ones), its outstanding count is zero, and `wake_valid_o` and `cpl_valid_o` are low.
- R2: A load with extra count N sets the entry's outstanding count to N+1 and marks it pinned when N is nonzero. With N equal to zero, a single writeback makes the entry ready and wakes consumers.
- R3: Each writeback to an entry whose count is above one lowers the count by one, produces no wakeup, and leaves the ready bit unchanged.
- R4: The writeback that brings the count from one to zero sets the entry's ready bit and causes exactly one wakeup carrying that index, both visible on the clock edge that samples the writeback.
- R5: Every writeback gives `cpl_valid_o` high with the instruction's tag one edge later. `cpl_pinned_o` is 1 when the written entry was loaded with N nonzero and has not yet completed, including on its final write; otherwise it is 0.
- R6: A clear makes the addressed entry's ready bit 0 on the next edge.
- R7: When a clear and a completing writeback hit the same entry in one cycle, the ready bit ends 0, and the wakeup is still broadcast.
- R8: When a load and a writeback hit the same entry in one cycle, the load sets the new count. The writeback's own wakeup and pinned flag are judged on the count held before that cycle.
- R9: A writeback to an entry whose count is already zero keeps the count at zero, leaves the entry ready, and broadcasts a wakeup with `cpl_pinned_o` 0.
- R10: `wake_valid_o` is a one-cycle pulse. It is high only on the edge right after a completing writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Rename loads an outstanding-write count |
| ld_idx_i | input | IDX_W | Physical register being loaded |
| ld_extra_i | input | 3 | Extra pinned writes N (count becomes N+1) |
| clr_valid_i | input | 1 | Rename clears a ready bit |
| clr_idx_i | input | IDX_W | Physical register being cleared |
| wb_valid_i | input | 1 | A write completes this cycle |
| wb_idx_i | input | IDX_W | Destination of the completing write |
| wb_tag_i | input | TAG_W | Tag of the completing instruction |
| wake_valid_o | output | 1 | Wakeup broadcast pulse |
| wake_idx_o | output | IDX_W | Register whose consumers may wake |
| cpl_valid_o | output | 1 | Completion report for one instruction |
| cpl_tag_o | output | TAG_W | Tag of the reported instruction |
| cpl_pinned_o | output | 1 | The reported instruction wrote a pinned register |
| ready_o | output | NPHYS | Ready bit of each physical register |

## Verification
A corrupted outstanding count shows up at the ports at the next writeback to that entry. A count that is too low fires the wakeup early, in the middle of a pinned run. A count that is too high swallows the final wakeup and leaves the ready bit clear. A stale pinned bit is visible on `cpl_pinned_o` one edge after any writeback, and a wrong clear/set priority is visible on `ready_o` on the edge that follows the collision. The vector walk places each writeback of a pinned run on its own cycle, so a single off-by-one shows up in the first vector that disagrees.

// File: rtl/pinwb_pkg.sv
package pinwb_pkg;

    // Largest number of extra pinned writes rename may request
    localparam int unsigned PW_MAX_EXTRA = 7;
    localparam int unsigned PW_EXTRA_W   = $clog2(PW_MAX_EXTRA + 1);
    localparam int unsigned PW_CNT_W     = $clog2(PW_MAX_EXTRA + 2);

    typedef logic [PW_CNT_W-1:0]   pw_cnt_t;
    typedef logic [PW_EXTRA_W-1:0] pw_extra_t;

    // State kept for one physical register
    typedef struct packed {
        logic    rdy;
        logic    pin;
        pw_cnt_t cnt;
    } pw_entry_t;

endpackage

// File: rtl/pinwb_entry.sv
module pinwb_entry
    import pinwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ld_hit_i,
    input  pw_extra_t ld_extra_i,
    input  logic      clr_hit_i,
    input  logic      wb_hit_i,
    output logic      rdy_o,
    output logic      done_o,
    output logic      pinwr_o
);

    pw_entry_t st_q, st_d;
    logic      done_d, pinwr_d;

    always_comb begin
        st_d    = st_q;
        done_d  = 1'b0;
        pinwr_d = 1'b0;
        if (wb_hit_i) begin
            pinwr_d = st_q.pin;
            if (st_q.cnt <= pw_cnt_t'(1)) begin
                st_d.cnt = '0;
                st_d.rdy = 1'b1;
                st_d.pin = 1'b0;
                done_d   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - pw_cnt_t'(1);
            end
        end
        // a new rename mapping overrides the write path
        if (ld_hit_i) begin
            st_d.cnt = pw_cnt_t'(ld_extra_i) + pw_cnt_t'(1);
            st_d.pin = |ld_extra_i;
        end
        // clear wins over set
        if (clr_hit_i) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rdy: 1'b1, pin: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_o   = st_q.rdy;
    assign done_o  = done_d;
    assign pinwr_o = pinwr_d;

    // R2: a pinned entry always has writes outstanding
    p_pin_has_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pin |-> (st_q.cnt != '0));

    // R4: last write leaves the entry ready with nothing outstanding
    p_last_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_hit_i && !ld_hit_i && !clr_hit_i && st_q.cnt == pw_cnt_t'(1))
        |=> (rdy_o && st_q.cnt == '0));

    // R6 / R7: a clear always leaves the entry not ready
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit_i |=> !rdy_o);

endmodule

// File: rtl/pinwb_bcast.sv
module pinwb_bcast #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_valid_i,
    input  logic [IDX_W-1:0] wb_idx_i,
    input  logic [TAG_W-1:0] wb_tag_i,
    input  logic             done_i,
    input  logic             pinwr_i,
    output logic             wake_valid_o,
    output logic [IDX_W-1:0] wake_idx_o,
    output logic             cpl_valid_o,
    output logic [TAG_W-1:0] cpl_tag_o,
    output logic             cpl_pinned_o
);

    typedef struct packed {
        logic             wake;
        logic [IDX_W-1:0] widx;
        logic             cpl;
        logic [TAG_W-1:0] tag;
        logic             pin;
    } bc_t;

    bc_t bc_q, bc_d;

    always_comb begin
        bc_d      = '0;
        bc_d.cpl  = wb_valid_i;
        bc_d.wake = wb_valid_i & done_i;
        if (wb_valid_i) begin
            bc_d.tag  = wb_tag_i;
            bc_d.pin  = pinwr_i;
            bc_d.widx = wb_idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_q <= '0;
        end else begin
            bc_q <= bc_d;
        end
    end

    assign wake_valid_o = bc_q.wake;
    assign wake_idx_o   = bc_q.widx;
    assign cpl_valid_o  = bc_q.cpl;
    assign cpl_tag_o    = bc_q.tag;
    assign cpl_pinned_o = bc_q.pin;

    // R10: a wakeup pulse only follows a writeback
    p_pulse_follows_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> $past(wb_valid_i));

    // R5: a wakeup is always reported together with a completion
    p_wake_with_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> cpl_valid_o);

endmodule

// File: rtl/pinwb_scoreboard.sv
module pinwb_scoreboard
    import pinwb_pkg::*;
#(
    parameter int unsigned NPHYS = 16,
    parameter int unsigned TAG_W = 6,
    localparam int unsigned IDX_W = $clog2(NPHYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid_i,
    input  logic [IDX_W-1:0]      ld_idx_i,
    input  logic [PW_EXTRA_W-1:0] ld_extra_i,
    input  logic                  clr_valid_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    input  logic                  wb_valid_i,
    input  logic [IDX_W-1:0]      wb_idx_i,
    input  logic [TAG_W-1:0]      wb_tag_i,
    output logic                  wake_valid_o,
    output logic [IDX_W-1:0]      wake_idx_o,
    output logic                  cpl_valid_o,
    output logic [TAG_W-1:0]      cpl_tag_o,
    output logic                  cpl_pinned_o,
    output logic [NPHYS-1:0]      ready_o
);

    logic [NPHYS-1:0] done_vec, pin_vec;

    for (genvar g = 0; g < NPHYS; g++) begin : g_ent
        pinwb_entry u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_hit_i   (ld_valid_i  && ld_idx_i  == IDX_W'(g)),
            .ld_extra_i (ld_extra_i),
            .clr_hit_i  (clr_valid_i && clr_idx_i == IDX_W'(g)),
            .wb_hit_i   (wb_valid_i  && wb_idx_i  == IDX_W'(g)),
            .rdy_o      (ready_o[g]),
            .done_o     (done_vec[g]),
            .pinwr_o    (pin_vec[g])
        );
    end

    pinwb_bcast #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bcast (
        .clk          (clk),
        .rst_n        (rst_n),
        .wb_valid_i   (wb_valid_i),
        .wb_idx_i     (wb_idx_i),
        .wb_tag_i     (wb_tag_i),
        .done_i       (|done_vec),
        .pinwr_i      (|pin_vec),
        .wake_valid_o (wake_valid_o),
        .wake_idx_o   (wake_idx_o),
        .cpl_valid_o  (cpl_valid_o),
        .cpl_tag_o    (cpl_tag_o),
        .cpl_pinned_o (cpl_pinned_o)
    );

    // R4: at most one entry completes per cycle
    p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));

    // R4 / R7: a woken register is ready unless it was cleared alongside
    p_wake_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> (ready_o[wake_idx_o] ||
                          $past(clr_valid_i && clr_idx_i == wake_idx_o)));

endmodule

// File: tb/pinwb_scoreboard_test.sv
module pinwb_scoreboard_test;

    localparam int NPHYS = 16;
    localparam int IDX_W = 4;
    localparam int TAG_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid_i = 1'b0, clr_valid_i = 1'b0, wb_valid_i = 1'b0;
    logic [IDX_W-1:0] ld_idx_i = '0, clr_idx_i = '0, wb_idx_i = '0;
    logic [2:0] ld_extra_i = '0;
    logic [TAG_W-1:0] wb_tag_i = '0;
    logic wake_valid_o, cpl_valid_o, cpl_pinned_o;
    logic [IDX_W-1:0] wake_idx_o;
    logic [TAG_W-1:0] cpl_tag_o;
    logic [NPHYS-1:0] ready_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    pinwb_scoreboard #(.NPHYS(NPHYS), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid_i(ld_valid_i), .ld_idx_i(ld_idx_i), .ld_extra_i(ld_extra_i),
        .clr_valid_i(clr_valid_i), .clr_idx_i(clr_idx_i),
        .wb_valid_i(wb_valid_i), .wb_idx_i(wb_idx_i), .wb_tag_i(wb_tag_i),
        .wake_valid_o(wake_valid_o), .wake_idx_o(wake_idx_o),
        .cpl_valid_o(cpl_valid_o), .cpl_tag_o(cpl_tag_o),
        .cpl_pinned_o(cpl_pinned_o), .ready_o(ready_o)
    );

    typedef struct packed {
        logic       ldv;  logic [3:0] ldi; logic [2:0] ldn;
        logic       clv;  logic [3:0] cli;
        logic       wbv;  logic [3:0] wbi; logic [5:0] tag;
        logic       ewk;  logic [3:0] ewi; logic       epn;
        logic [3:0] chk;  logic       erd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1,4'd3,3'd2, 1'b1,4'd3, 1'b0,4'd0,6'd0,  1'b0,4'd0,1'b0, 4'd3,1'b0}, // R2 R6 pin reg 3 for 3 writes
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd3,6'd1,  1'b0,4'd0,1'b1, 4'd3,1'b0}, // R3 R5
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd3,6'd2,  1'b0,4'd0,1'b1, 4'd3,1'b0}, // R3
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd3,6'd3,  1'b1,4'd3,1'b1, 4'd3,1'b1}, // R4 R5 last write
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b0,4'd0,6'd0,  1'b0,4'd0,1'b0, 4'd3,1'b1}, // R10 idle
        '{1'b1,4'd5,3'd0, 1'b1,4'd5, 1'b0,4'd0,6'd0,  1'b0,4'd0,1'b0, 4'd5,1'b0}, // R2 R6 unpinned
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd5,6'd4,  1'b1,4'd5,1'b0, 4'd5,1'b1}, // R2 single write
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd5,6'd5,  1'b1,4'd5,1'b0, 4'd5,1'b1}, // R9 count already zero
        '{1'b1,4'd7,3'd1, 1'b1,4'd7, 1'b0,4'd0,6'd0,  1'b0,4'd0,1'b0, 4'd7,1'b0}, // R2
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd7,6'd6,  1'b0,4'd0,1'b1, 4'd7,1'b0}, // R3
        '{1'b0,4'd0,3'd0, 1'b1,4'd7, 1'b1,4'd7,6'd7,  1'b1,4'd7,1'b1, 4'd7,1'b0}, // R7 clear beats set
        '{1'b1,4'd9,3'd0, 1'b1,4'd9, 1'b0,4'd0,6'd0,  1'b0,4'd0,1'b0, 4'd9,1'b0}, // R6
        '{1'b1,4'd9,3'd1, 1'b0,4'd0, 1'b1,4'd9,6'd8,  1'b1,4'd9,1'b0, 4'd9,1'b1}, // R8 load and write together
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd9,6'd9,  1'b0,4'd0,1'b1, 4'd9,1'b1}, // R8 new count governs
        '{1'b0,4'd0,3'd0, 1'b0,4'd0, 1'b1,4'd9,6'd10, 1'b1,4'd9,1'b1, 4'd9,1'b1}  // R8 R4
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ld_valid_i = v.ldv; ld_idx_i = v.ldi; ld_extra_i = v.ldn;
        clr_valid_i = v.clv; clr_idx_i = v.cli;
        wb_valid_i = v.wbv; wb_idx_i = v.wbi; wb_tag_i = v.tag;
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t idle;
        idle = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(ready_o == '1, "R1 ready", int'(ready_o), 65535);
        chk(!wake_valid_o && !cpl_valid_o, "R1 outputs", int'(wake_valid_o), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(posedge clk); #1;
            chk(wake_valid_o == VEC[i].ewk, $sformatf("R4/R3 wake v%0d", i),
                int'(wake_valid_o), int'(VEC[i].ewk));
            if (VEC[i].ewk)
                chk(wake_idx_o == VEC[i].ewi, $sformatf("R4 wake idx v%0d", i),
                    int'(wake_idx_o), int'(VEC[i].ewi));
            chk(cpl_valid_o == VEC[i].wbv, $sformatf("R5 cpl v%0d", i),
                int'(cpl_valid_o), int'(VEC[i].wbv));
            if (VEC[i].wbv) begin
                chk(cpl_tag_o == VEC[i].tag, $sformatf("R5 tag v%0d", i),
                    int'(cpl_tag_o), int'(VEC[i].tag));
                chk(cpl_pinned_o == VEC[i].epn, $sformatf("R5 pinned v%0d", i),
                    int'(cpl_pinned_o), int'(VEC[i].epn));
            end
            chk(ready_o[VEC[i].chk] == VEC[i].erd, $sformatf("R6/R7 ready v%0d", i),
                int'(ready_o[VEC[i].chk]), int'(VEC[i].erd));
        end

        // R10: single writeback to an idle ready entry, then silence
        @(negedge clk);
        idle.wbv = 1'b1; idle.wbi = 4'd2; idle.tag = 6'd33;
        drive(idle);
        @(posedge clk); #1;
        chk(wake_valid_o && wake_idx_o == 4'd2, "R10 pulse", int'(wake_valid_o), 1);
        @(negedge clk);
        drive('0);
        @(posedge clk); #1;
        chk(!wake_valid_o, "R10 pulse ends", int'(wake_valid_o), 0);
        chk(!cpl_valid_o, "R5 no cpl when idle", int'(cpl_valid_o), 0);

        // R1: reset restores all ready bits after a clear
        @(negedge clk);
        idle = '0; idle.clv = 1'b1; idle.cli = 4'd4;
        drive(idle);
        @(posedge clk); #1;
        chk(!ready_o[4], "R6 clear reg 4", int'(ready_o[4]), 0);
        @(negedge clk);
        drive('0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        chk(ready_o == '1, "R1 ready after reset", int'(ready_o), 65535);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule